// File: doc/BRIEF.md
# PS/2 Wheel-Mouse Packet Receiver

This block listens to the clock and data lines of a PS/2 mouse that reports in the four-byte wheel format. Both lines are asynchronous to the fast system clock, so they are first brought through a synchronizer chain. The receiver captures one data bit on each high-to-low transition of the synchronized mouse clock and collects a whole report of four 11-bit frames, 44 bits in all, before it decodes any field.

When the last bit of a report arrives, all four frames are checked at once. Each frame needs a low start bit and a high stop bit, and its data plus parity must hold an odd number of ones. A report that passes every check loads the registered movement, sign, overflow and button outputs and raises a one-cycle valid strobe. A report that fails any check is dropped without a trace. If the mouse clock stays idle too long in the middle of a report, the partial report is thrown away and the receiver lines up again on the next frame.

Top module: `ps2_mouse_rx`

## Requirements
- R1: While reset is high and in the first cycle after it, every output is 0 and the valid strobe is low.
- R2: Bits are captured on falling edges of the mouse clock, least significant first. In frame k (k = 0..3, received in order), bit 0 is start, bits 1..8 are the data byte LSB first, bit 9 is parity and bit 10 is stop. For a good report: left button = byte0 bit 0, right button = byte0 bit 1, X sign = byte0 bit 4 (0 means rightward), Y sign = byte0 bit 5 (1 means downward), X overflow = byte0 bit 6, Y overflow = byte0 bit 7, X magnitude = byte1 and Y magnitude = byte2. Byte0 bits 2 and 3 and all of byte3 do not reach any output.
- R3: Each good report produces exactly one valid pulse, one system clock cycle wide.
- R4: A report with a start bit of 1 in any frame produces no valid pulse and leaves the outputs unchanged.
- R5: A report with a stop bit of 0 in any frame produces no valid pulse and leaves the outputs unchanged.
- R6: A report in which any frame's eight data bits plus parity bit hold an even number of ones produces no valid pulse and leaves the outputs unchanged.
- R7: Between valid pulses all field outputs hold the value of the last good report.
- R8: If no mouse-clock falling edge arrives for IDLE_LIMIT system cycles while a report is partly received, the partial bits are discarded, and the next complete report is decoded correctly.
- R9: Reports sent back to back with short gaps are all accepted, one valid pulse each, and a dropped report does not disturb the alignment of the next one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| ps2_clk_in | input | 1 | Mouse clock line, asynchronous |
| ps2_dat_in | input | 1 | Mouse data line, asynchronous |
| mv_x | output | 8 | X movement magnitude |
| mv_y | output | 8 | Y movement magnitude |
| sgn_x | output | 1 | X direction, 0 = right |
| sgn_y | output | 1 | Y direction, 1 = down |
| ovf_x | output | 1 | X overflow flag |
| ovf_y | output | 1 | Y overflow flag |
| btn_left | output | 1 | Left button pressed |
| btn_right | output | 1 | Right button pressed |
| pkt_valid | output | 1 | One-cycle strobe on a new good report |

## Verification
The bench sweeps every combination of the six mapped header flags and varies the X and Y bytes arithmetically. A swapped or shifted bit map, or capture on the wrong clock edge, shows up as a field mismatch in that sweep. Each kind of framing error is placed in each of the four frames. A design that checks only some frames, or that inverts a start, stop or parity test, would pulse valid or change the outputs on a corrupted report. Partial reports cut off after a few bits or after two frames test the idle timeout. A receiver without that timeout would stay misaligned and either miss the next report or decode it as garbage.

// File: rtl/ps2m_pkg.sv
package ps2m_pkg;
  localparam int FRAME_BITS = 11;
  localparam int FRAMES     = 4;
  localparam int PKT_BITS   = FRAME_BITS * FRAMES;

  // header byte layout, MSB first
  typedef struct packed {
    logic ovf_y;
    logic ovf_x;
    logic sgn_y;
    logic sgn_x;
    logic always1;
    logic mid;
    logic btn_r;
    logic btn_l;
  } hdr_t;
endpackage

// File: rtl/ps2m_sync.sv
module ps2m_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic async_clk,
  input  logic async_dat,
  output logic fall,
  output logic dat
);
  localparam int TOP = STAGES - 1;

  logic [TOP:0] c_sr;
  logic [TOP:0] d_sr;
  logic         c_prev;

  generate
    if (STAGES < 2) begin : g_bad
      initial $error("ps2m_sync needs at least two stages");
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) begin
      c_sr   <= '1;
      d_sr   <= '1;
      c_prev <= 1'b1;
    end else begin
      c_sr   <= {c_sr[TOP-1:0], async_clk};
      d_sr   <= {d_sr[TOP-1:0], async_dat};
      c_prev <= c_sr[TOP];
    end
  end

  assign fall = c_prev & ~c_sr[TOP];
  assign dat  = d_sr[TOP];

  // a falling edge can never be reported two cycles running
  assert_fall_single_R2: assert property (@(posedge clk) disable iff (rst)
    fall |=> !fall);
endmodule

// File: rtl/ps2m_frame_chk.sv
module ps2m_frame_chk #(
  parameter int FBITS = 11
) (
  input  logic [FBITS-1:0] frame,
  output logic             ok
);
  logic start_ok, stop_ok, par_ok;
  always_comb begin
    start_ok = ~frame[0];
    stop_ok  = frame[FBITS-1];
    par_ok   = ^frame[FBITS-2:1];
    ok       = start_ok & stop_ok & par_ok;
  end
endmodule

// File: rtl/ps2m_deser.sv
module ps2m_deser #(
  parameter int PKT_BITS   = 44,
  parameter int IDLE_LIMIT = 200000
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                fall,
  input  logic                dat,
  output logic [PKT_BITS-1:0] pkt,
  output logic                rdy
);
  localparam int CW = $clog2(PKT_BITS);
  localparam int IW = $clog2(IDLE_LIMIT + 1);
  localparam logic [CW-1:0] LAST_BIT = CW'(PKT_BITS - 1);
  localparam logic [IW-1:0] IDLE_END = IW'(IDLE_LIMIT - 1);

  logic [CW-1:0] bit_cnt;
  logic [IW-1:0] idle_cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      bit_cnt  <= '0;
      idle_cnt <= '0;
      pkt      <= '0;
      rdy      <= 1'b0;
    end else begin
      rdy <= 1'b0;
      if (fall) begin
        pkt      <= {dat, pkt[PKT_BITS-1:1]};
        idle_cnt <= '0;
        if (bit_cnt == LAST_BIT) begin
          bit_cnt <= '0;
          rdy     <= 1'b1;
        end else begin
          bit_cnt <= bit_cnt + 1'b1;
        end
      end else if (bit_cnt != '0) begin
        if (idle_cnt == IDLE_END) begin
          bit_cnt  <= '0;
          idle_cnt <= '0;
        end else begin
          idle_cnt <= idle_cnt + 1'b1;
        end
      end else begin
        idle_cnt <= '0;
      end
    end
  end

  assert_cnt_range_R9: assert property (@(posedge clk) disable iff (rst)
    bit_cnt <= LAST_BIT);

  assert_rdy_pulse_R3: assert property (@(posedge clk) disable iff (rst)
    rdy |=> !rdy);

  assert_idle_flush_R8: assert property (@(posedge clk) disable iff (rst)
    (!fall && bit_cnt != '0 && idle_cnt == IDLE_END) |=> (bit_cnt == '0));
endmodule

// File: rtl/ps2_mouse_rx.sv
module ps2_mouse_rx #(
  parameter int SYNC_STAGES = 2,
  parameter int IDLE_LIMIT  = 200000
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       ps2_clk_in,
  input  logic       ps2_dat_in,
  output logic [7:0] mv_x,
  output logic [7:0] mv_y,
  output logic       sgn_x,
  output logic       sgn_y,
  output logic       ovf_x,
  output logic       ovf_y,
  output logic       btn_left,
  output logic       btn_right,
  output logic       pkt_valid
);
  import ps2m_pkg::*;

  logic                s_fall, s_dat;
  logic [PKT_BITS-1:0] pkt;
  logic                rdy;
  logic [FRAMES-1:0]   frame_ok;
  logic                all_ok, accept;
  logic [7:0]          byte_v [FRAMES];
  hdr_t                hdr;

  ps2m_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst(rst),
    .async_clk(ps2_clk_in), .async_dat(ps2_dat_in),
    .fall(s_fall), .dat(s_dat)
  );

  ps2m_deser #(.PKT_BITS(PKT_BITS), .IDLE_LIMIT(IDLE_LIMIT)) u_deser (
    .clk(clk), .rst(rst),
    .fall(s_fall), .dat(s_dat),
    .pkt(pkt), .rdy(rdy)
  );

  generate
    for (genvar g = 0; g < FRAMES; g++) begin : g_frame
      ps2m_frame_chk #(.FBITS(FRAME_BITS)) u_chk (
        .frame(pkt[g*FRAME_BITS +: FRAME_BITS]),
        .ok(frame_ok[g])
      );
      assign byte_v[g] = pkt[g*FRAME_BITS + 1 +: 8];
    end
  endgenerate

  assign all_ok = &frame_ok;
  assign accept = rdy & all_ok;
  assign hdr    = hdr_t'(byte_v[0]);

  always_ff @(posedge clk) begin
    if (rst) begin
      mv_x      <= '0;
      mv_y      <= '0;
      sgn_x     <= 1'b0;
      sgn_y     <= 1'b0;
      ovf_x     <= 1'b0;
      ovf_y     <= 1'b0;
      btn_left  <= 1'b0;
      btn_right <= 1'b0;
      pkt_valid <= 1'b0;
    end else begin
      pkt_valid <= accept;
      if (accept) begin
        mv_x      <= byte_v[1];
        mv_y      <= byte_v[2];
        sgn_x     <= hdr.sgn_x;
        sgn_y     <= hdr.sgn_y;
        ovf_x     <= hdr.ovf_x;
        ovf_y     <= hdr.ovf_y;
        btn_left  <= hdr.btn_l;
        btn_right <= hdr.btn_r;
      end
    end
  end

  assert_valid_from_ready_R2: assert property (@(posedge clk) disable iff (rst)
    pkt_valid |-> $past(rdy));

  assert_valid_one_cycle_R3: assert property (@(posedge clk) disable iff (rst)
    pkt_valid |=> !pkt_valid);

  assert_bad_frame_dropped_R4: assert property (@(posedge clk) disable iff (rst)
    (rdy && !all_ok) |=> !pkt_valid);

  assert_fields_hold_R7: assert property (@(posedge clk) disable iff (rst)
    !pkt_valid |-> ($stable(mv_x) && $stable(mv_y) && $stable(sgn_x) &&
                    $stable(sgn_y) && $stable(ovf_x) && $stable(ovf_y) &&
                    $stable(btn_left) && $stable(btn_right)));
endmodule

// File: tb/tb_ps2_mouse_rx.sv
module tb_ps2_mouse_rx;
  localparam int IDLE = 400;
  localparam int HALF = 10;
  localparam int GAP  = 30;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic ps2_c = 1'b1;
  logic ps2_d = 1'b1;
  logic [7:0] mv_x, mv_y;
  logic sgn_x, sgn_y, ovf_x, ovf_y, btn_left, btn_right, pkt_valid;

  int n_chk = 0, n_fail = 0;
  int pulses = 0, hi_cycles = 0;
  bit done = 0;

  always #10 clk = ~clk;  // 50 MHz

  ps2_mouse_rx #(.SYNC_STAGES(2), .IDLE_LIMIT(IDLE)) dut (
    .clk(clk), .rst(rst), .ps2_clk_in(ps2_c), .ps2_dat_in(ps2_d),
    .mv_x(mv_x), .mv_y(mv_y), .sgn_x(sgn_x), .sgn_y(sgn_y),
    .ovf_x(ovf_x), .ovf_y(ovf_y), .btn_left(btn_left),
    .btn_right(btn_right), .pkt_valid(pkt_valid)
  );

  logic prev_v = 1'b0;
  always @(negedge clk) begin
    if (!rst) begin
      if (pkt_valid) hi_cycles++;
      if (pkt_valid && !prev_v) pulses++;
    end
    prev_v <= pkt_valid;
  end

  function automatic logic [21:0] outs();
    return {btn_left, btn_right, sgn_x, sgn_y, ovf_x, ovf_y, mv_x, mv_y};
  endfunction

  function automatic logic [21:0] expect_of(logic [7:0] b0, logic [7:0] x, logic [7:0] y);
    return {b0[0], b0[1], b0[4], b0[5], b0[6], b0[7], x, y};
  endfunction

  task automatic chk(bit ok, string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wait_cyc(int n);
    repeat (n) @(negedge clk);
  endtask

  // kind: 0 good, 1 bad start, 2 bad stop, 3 bad parity
  task automatic send_frame(logic [7:0] b, int kind, int nbits);
    logic [10:0] f;
    f = {1'b1, ~^b, b, 1'b0};
    if (kind == 1) f[0] = 1'b1;
    if (kind == 2) f[10] = 1'b0;
    if (kind == 3) f[9] = ~f[9];
    for (int i = 0; i < nbits; i++) begin
      ps2_d = f[i];
      wait_cyc(HALF);
      ps2_c = 1'b0;
      wait_cyc(HALF);
      ps2_c = 1'b1;
    end
    ps2_d = 1'b1;
    wait_cyc(GAP);
  endtask

  task automatic send_pkt(logic [7:0] b0, logic [7:0] x, logic [7:0] y,
                          logic [7:0] b3, int bad_frame, int kind);
    logic [7:0] bytes [4];
    bytes[0] = b0; bytes[1] = x; bytes[2] = y; bytes[3] = b3;
    for (int k = 0; k < 4; k++)
      send_frame(bytes[k], (k == bad_frame) ? kind : 0, 11);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      n_fail++; n_chk++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    int p0;
    logic [21:0] last;
    logic [7:0] b0, x, y;

    wait_cyc(3);
    chk(outs() == 22'd0 && !pkt_valid, "R1 outputs during reset", {9'd0, outs(), pkt_valid}, 0);
    rst = 1'b0;
    wait_cyc(1);
    chk(outs() == 22'd0 && !pkt_valid, "R1 outputs after reset", {9'd0, outs(), pkt_valid}, 0);
    wait_cyc(20);

    // sweep of all header flag combinations, back to back
    for (int i = 0; i < 64; i++) begin
      b0 = {i[5], i[4], i[3], i[2], 1'b1, i[0] ^ i[1], i[1], i[0]};
      x  = 8'((i * 37 + 5) & 255);
      y  = 8'((i * 91 + 13) & 255);
      p0 = pulses;
      send_pkt(b0, x, y, 8'((i * 7) & 255), -1, 0);
      chk(pulses == p0 + 1, "R9 one pulse per back-to-back report", pulses, p0 + 1);
      chk(outs() == expect_of(b0, x, y), "R2 field map", outs(), expect_of(b0, x, y));
    end
    chk(hi_cycles == pulses, "R3 pulse width one cycle", hi_cycles, pulses);

    // corrupted frames, every kind in every frame
    for (int kind = 1; kind <= 3; kind++) begin
      for (int fr = 0; fr < 4; fr++) begin
        last = outs();
        p0 = pulses;
        send_pkt(8'hF3, 8'h5A, 8'hA5, 8'h0F, fr, kind);
        if (kind == 1) begin
          chk(pulses == p0, "R4 bad start no pulse", pulses, p0);
          chk(outs() == last, "R4 bad start outputs held", outs(), last);
        end else if (kind == 2) begin
          chk(pulses == p0, "R5 bad stop no pulse", pulses, p0);
          chk(outs() == last, "R5 bad stop outputs held", outs(), last);
        end else begin
          chk(pulses == p0, "R6 bad parity no pulse", pulses, p0);
          chk(outs() == last, "R6 bad parity outputs held", outs(), last);
        end
        p0 = pulses;
        send_pkt(8'h19, 8'(fr * 16 + kind), 8'(200 - fr), 8'h00, -1, 0);
        chk(pulses == p0 + 1, "R9 realigned after dropped report", pulses, p0 + 1);
        chk(outs() == expect_of(8'h19, 8'(fr * 16 + kind), 8'(200 - fr)),
            "R7 good report after drop", outs(),
            expect_of(8'h19, 8'(fr * 16 + kind), 8'(200 - fr)));
      end
    end

    // idle timeout: partial inside a frame, then partial after two frames
    last = outs();
    p0 = pulses;
    send_frame(8'h3C, 0, 5);
    wait_cyc(IDLE + 40);
    chk(outs() == last && pulses == p0, "R7 hold through partial", outs(), last);
    send_pkt(8'h29, 8'h11, 8'hEE, 8'h00, -1, 0);
    chk(pulses == p0 + 1, "R8 report after partial bits", pulses, p0 + 1);
    chk(outs() == expect_of(8'h29, 8'h11, 8'hEE), "R8 fields after partial bits",
        outs(), expect_of(8'h29, 8'h11, 8'hEE));

    p0 = pulses;
    send_frame(8'hC8, 0, 11);
    send_frame(8'h77, 0, 11);
    wait_cyc(IDLE + 40);
    send_pkt(8'hDA, 8'h80, 8'h01, 8'h00, -1, 0);
    chk(pulses == p0 + 1, "R8 report after partial frames", pulses, p0 + 1);
    chk(outs() == expect_of(8'hDA, 8'h80, 8'h01), "R8 fields after partial frames",
        outs(), expect_of(8'hDA, 8'h80, 8'h01));

    wait_cyc(5);
    chk(hi_cycles == pulses, "R3 pulse width one cycle overall", hi_cycles, pulses);

    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule